// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Result Pair

This block performs 32-bit integer multiplication and division for a simple in-order processor core and owns the two architectural result registers, HI and LO. The core presents a one-cycle request made of a six-bit function code and two source operands (`rs`, `rt`). Multiply and divide requests start a bit-serial sequence. Shift-add is used for products and restoring subtraction for quotients. The sequence takes one step per cycle, and `busy_o` stays high until the result has been written into HI/LO.

A product is split into HI (upper word) and LO (lower word). A division leaves the quotient in LO and the remainder in HI. Signed operations work on magnitudes and correct the signs when they finish. HI and LO can also be written directly from `rs`, or read back for a register write. A read that arrives while an operation is running raises `stall_o` so the core can hold the instruction. Requests that arrive while busy are dropped.

Top module: `mdu_top`

## Requirements
- R1: After reset, `busy_o` is low and both HI and LO read back as zero.
- R2: Function code 011001 (unsigned multiply) writes bits 63..32 of the unsigned 64-bit product rs*rt into HI and bits 31..0 into LO.
- R3: Function code 011000 (signed multiply) does the same with both operands taken as two's-complement values.
- R4: Function code 011011 (unsigned divide) puts rs/rt in LO and rs mod rt in HI.
- R5: Function code 011010 (signed divide) truncates the quotient toward zero and gives the remainder the sign of the dividend. The case -2^31 / -1 yields quotient 0x80000000 and remainder 0.
- R6: A divide with rt = 0, signed or unsigned, completes normally with LO = 0xFFFFFFFF and HI = rs.
- R7: A multiply or divide request taken while idle raises `busy_o` from the next clock edge for exactly 32 cycles. HI/LO take the new result at the edge where `busy_o` falls.
- R8: While `busy_o` is high, every request (multiply, divide or move-to) is ignored. The running operation's result and its timing are unchanged.
- R9: A read request (010000 reads HI, 010010 reads LO) with `start_i` high while idle drives the register value on `rd_data_o` in the same cycle with `stall_o` low. While busy, it drives `stall_o` high and `rd_data_o` zero.
- R10: Function code 010001 loads HI from rs and 010011 loads LO from rs at the next edge. The other register is unchanged and `busy_o` stays low.
- R11: Any other function code presented with `start_i` changes neither HI, LO nor `busy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, one cycle per request |
| func_i | input | 6 | Function code of the request |
| rs_i | input | 32 | First operand / move-to source |
| rt_i | input | 32 | Second operand |
| busy_o | output | 1 | Operation in progress |
| stall_o | output | 1 | Read request must be held (unit busy) |
| rd_data_o | output | 32 | HI or LO value for a read request |

## Verification
Arithmetic results are due 32 clock edges after the edge that accepts the request. The bench drives each request on a falling edge and checks `busy_o` exactly on the falling edges just before and just after the 32nd step. It reads HI/LO only after that point. Read data and `stall_o` follow the request combinationally, so the bench samples them one time step after driving the read and never across an edge. Move-to writes are visible from the next cycle, so the following read checks them. Random signed and unsigned operands are mixed with directed cases: zero divisor, the most negative dividend over -1, all-ones products, and requests made while busy.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  localparam int unsigned FN_W = 6;

  typedef enum logic [FN_W-1:0] {
    FN_MFHI  = 6'b010000,
    FN_MTHI  = 6'b010001,
    FN_MFLO  = 6'b010010,
    FN_MTLO  = 6'b010011,
    FN_MULT  = 6'b011000,
    FN_MULTU = 6'b011001,
    FN_DIV   = 6'b011010,
    FN_DIVU  = 6'b011011
  } mdu_fn_e;

  // Sign-correction flags captured when an operation is accepted
  typedef struct packed {
    logic is_div;
    logic neg_prod;
    logic neg_quo;
    logic neg_rem;
    logic den_zero;
  } fix_flags_t;

endpackage

// File: rtl/mdu_opnd_prep.sv
module mdu_opnd_prep
  import mdu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         signed_i,
  input  logic         is_div_i,
  output logic [W-1:0] mag_a_o,
  output logic [W-1:0] mag_b_o,
  output fix_flags_t   flags_o
);

  logic sa, sb, bz;

  always_comb begin
    sa      = signed_i & a_i[W-1];
    sb      = signed_i & b_i[W-1];
    bz      = (b_i == '0);
    mag_a_o = sa ? (~a_i + 1'b1) : a_i;
    mag_b_o = sb ? (~b_i + 1'b1) : b_i;
    flags_o.is_div   = is_div_i;
    flags_o.neg_prod = ~is_div_i & (sa ^ sb);
    // a zero divisor keeps the all-ones quotient uncorrected
    flags_o.neg_quo  = is_div_i & (sa ^ sb) & ~bz;
    flags_o.neg_rem  = is_div_i & sa;
    flags_o.den_zero = is_div_i & bz;
  end

endmodule

// File: rtl/mdu_iter.sv
module mdu_iter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         div_i,
  input  logic [W-1:0] mag_a_i,
  input  logic [W-1:0] mag_b_i,
  output logic         active_o,
  output logic         last_o,
  output logic [W-1:0] step_hi_o,
  output logic [W-1:0] step_lo_o
);

  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  acc_hi_q, acc_hi_d;
  logic [W-1:0]  acc_lo_q, acc_lo_d;
  logic [W-1:0]  opb_q, opb_d;
  logic          div_q, div_d;
  logic          act_q, act_d;
  logic [CW-1:0] cnt_q, cnt_d;

  logic [W:0]    m_sum;
  logic [W:0]    d_shift;
  logic [W+1:0]  d_diff;
  logic          d_fit;
  logic [W-1:0]  nx_hi, nx_lo;
  logic          last;

  // one shift-add or restoring-subtract step
  always_comb begin
    m_sum   = {1'b0, acc_hi_q} + (acc_lo_q[0] ? {1'b0, opb_q} : '0);
    d_shift = {acc_hi_q, acc_lo_q[W-1]};
    d_diff  = {1'b0, d_shift} - {2'b00, opb_q};
    d_fit   = ~d_diff[W+1];
    if (div_q) begin
      nx_hi = d_fit ? d_diff[W-1:0] : d_shift[W-1:0];
      nx_lo = {acc_lo_q[W-2:0], d_fit};
    end else begin
      nx_hi = m_sum[W:1];
      nx_lo = {m_sum[0], acc_lo_q[W-1:1]};
    end
  end

  assign last = act_q && (cnt_q == CW'(W - 1));

  always_comb begin
    acc_hi_d = acc_hi_q;
    acc_lo_d = acc_lo_q;
    opb_d    = opb_q;
    div_d    = div_q;
    act_d    = act_q;
    cnt_d    = cnt_q;
    if (load_i) begin
      acc_hi_d = '0;
      acc_lo_d = mag_a_i;
      opb_d    = mag_b_i;
      div_d    = div_i;
      act_d    = 1'b1;
      cnt_d    = '0;
    end else if (act_q) begin
      acc_hi_d = nx_hi;
      acc_lo_d = nx_lo;
      cnt_d    = cnt_q + 1'b1;
      if (last) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_hi_q <= '0;
      acc_lo_q <= '0;
      opb_q    <= '0;
      div_q    <= 1'b0;
      act_q    <= 1'b0;
      cnt_q    <= '0;
    end else if (load_i || act_q) begin
      acc_hi_q <= acc_hi_d;
      acc_lo_q <= acc_lo_d;
      opb_q    <= opb_d;
      div_q    <= div_d;
      act_q    <= act_d;
      cnt_q    <= cnt_d;
    end
  end

  assign active_o  = act_q;
  assign last_o    = last;
  assign step_hi_o = nx_hi;
  assign step_lo_o = nx_lo;

  // R7: step counter never passes the iteration count
  p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (cnt_q < CW'(W)));

  // R8: a new load never lands on a running sequence
  p_load_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !act_q);

endmodule

// File: rtl/mdu_result_fix.sv
module mdu_result_fix
  import mdu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] raw_hi_i,
  input  logic [W-1:0] raw_lo_i,
  input  fix_flags_t   flags_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);

  logic [2*W-1:0] prod;

  always_comb begin
    prod = {raw_hi_i, raw_lo_i};
    if (flags_i.neg_prod) prod = ~prod + 1'b1;
    if (flags_i.is_div) begin
      hi_o = flags_i.neg_rem ? (~raw_hi_i + 1'b1) : raw_hi_i;
      lo_o = flags_i.neg_quo ? (~raw_lo_i + 1'b1) : raw_lo_i;
    end else begin
      hi_o = prod[2*W-1:W];
      lo_o = prod[W-1:0];
    end
  end

endmodule

// File: rtl/mdu_top.sv
module mdu_top
  import mdu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [5:0]   func_i,
  input  logic [W-1:0] rs_i,
  input  logic [W-1:0] rt_i,
  output logic         busy_o,
  output logic         stall_o,
  output logic [W-1:0] rd_data_o
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic is_mul, is_div, is_signed, is_mthi, is_mtlo, is_mfhi, is_mflo;
  logic accept_md, wr_mthi, wr_mtlo;
  logic active, last;
  logic [W-1:0] mag_a, mag_b, step_hi, step_lo, fix_hi, fix_lo;
  fix_flags_t   flags_new, flags_q, flags_d;
  logic [W-1:0] hi_q, hi_d, lo_q, lo_d;
  logic         hi_en, lo_en;

  always_comb begin
    is_mul    = (func_i == FN_MULT) || (func_i == FN_MULTU);
    is_div    = (func_i == FN_DIV)  || (func_i == FN_DIVU);
    is_signed = (func_i == FN_MULT) || (func_i == FN_DIV);
    is_mthi   = (func_i == FN_MTHI);
    is_mtlo   = (func_i == FN_MTLO);
    is_mfhi   = (func_i == FN_MFHI);
    is_mflo   = (func_i == FN_MFLO);
    accept_md = start_i && !active && (is_mul || is_div);
    wr_mthi   = start_i && !active && is_mthi;
    wr_mtlo   = start_i && !active && is_mtlo;
  end

  mdu_opnd_prep #(.W(W)) prep_i (
    .a_i      (rs_i),
    .b_i      (rt_i),
    .signed_i (is_signed),
    .is_div_i (is_div),
    .mag_a_o  (mag_a),
    .mag_b_o  (mag_b),
    .flags_o  (flags_new)
  );

  mdu_iter #(.W(W)) iter_i (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .load_i    (accept_md),
    .div_i     (is_div),
    .mag_a_i   (mag_a),
    .mag_b_i   (mag_b),
    .active_o  (active),
    .last_o    (last),
    .step_hi_o (step_hi),
    .step_lo_o (step_lo)
  );

  mdu_result_fix #(.W(W)) fix_i (
    .raw_hi_i (step_hi),
    .raw_lo_i (step_lo),
    .flags_i  (flags_q),
    .hi_o     (fix_hi),
    .lo_o     (fix_lo)
  );

  // next-state for flags and the architectural pair
  always_comb begin
    flags_d = accept_md ? flags_new : flags_q;
    hi_en   = last || wr_mthi;
    lo_en   = last || wr_mtlo;
    hi_d    = last ? fix_hi : rs_i;
    lo_d    = last ? fix_lo : rs_i;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      flags_q <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
    end else begin
      if (accept_md) flags_q <= flags_d;
      if (hi_en)     hi_q    <= hi_d;
      if (lo_en)     lo_q    <= lo_d;
    end
  end

  always_comb begin
    busy_o    = active;
    stall_o   = start_i && active && (is_mfhi || is_mflo);
    rd_data_o = '0;
    if (start_i && !active) begin
      if (is_mfhi)      rd_data_o = hi_q;
      else if (is_mflo) rd_data_o = lo_q;
    end
  end

  // R7: an accepted request makes the unit busy on the next cycle
  p_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    accept_md |=> busy_o);

  // R8: HI/LO do not move while a sequence runs, except at its final step
  p_hilo_frozen_r8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (busy_o && !last) |=> ($stable(hi_q) && $stable(lo_q)));

  // R10: a move-to never starts a sequence
  p_move_idle_r10: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (wr_mthi || wr_mtlo) |=> !busy_o);

  // R6: zero divisor finishes with an all-ones quotient
  p_divzero_r6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (last && flags_q.den_zero) |-> (fix_lo == '1));

  // R9: stalled reads carry no data
  p_stall_nodata_r9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    stall_o |-> (rd_data_o == '0));

endmodule

// File: tb/mdu_top_tb_top.sv
module mdu_top_tb_top;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [5:0]  func_i;
  logic [31:0] rs_i, rt_i;
  logic        busy_o, stall_o;
  logic [31:0] rd_data_o;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  localparam logic [5:0] C_MFHI = 6'b010000, C_MTHI = 6'b010001,
                         C_MFLO = 6'b010010, C_MTLO = 6'b010011,
                         C_MULT = 6'b011000, C_MULTU = 6'b011001,
                         C_DIV  = 6'b011010, C_DIVU  = 6'b011011;

  mdu_top dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .func_i(func_i),
    .rs_i(rs_i), .rt_i(rt_i), .busy_o(busy_o), .stall_o(stall_o),
    .rd_data_o(rd_data_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  function automatic logic [63:0] exp_mul(input bit sgn, input logic [31:0] a, input logic [31:0] b);
    longint p;
    if (sgn) begin
      p = longint'($signed(a)) * longint'($signed(b));
      return p;
    end
    return {32'b0, a} * {32'b0, b};
  endfunction

  // returns {HI, LO}
  function automatic logic [63:0] exp_div(input bit sgn, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, q, r;
    if (b == 0) return {a, 32'hFFFF_FFFF};
    if (sgn) begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      q = sa / sb;
      r = sa % sb;
      return {r[31:0], q[31:0]};
    end
    return {a % b, a / b};
  endfunction

  task automatic issue(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
    start_i = 1'b1; func_i = f; rs_i = a; rt_i = b;
    @(negedge clk);
    start_i = 1'b0; func_i = 6'b0; rs_i = '0; rt_i = '0;
  endtask

  task automatic read_reg(input logic [5:0] f, output logic [31:0] v, output logic st);
    start_i = 1'b1; func_i = f;
    #1;
    v = rd_data_o; st = stall_o;
    @(negedge clk);
    start_i = 1'b0; func_i = 6'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 40 && busy_o; i++) @(negedge clk);
  endtask

  task automatic run_and_check(input string req, input logic [5:0] f,
                               input logic [31:0] a, input logic [31:0] b);
    logic [31:0] h, l; logic st;
    logic [63:0] e;
    bit sgn, dv;
    sgn = (f == C_MULT) || (f == C_DIV);
    dv  = (f == C_DIV) || (f == C_DIVU);
    e = dv ? exp_div(sgn, a, b) : exp_mul(sgn, a, b);
    issue(f, a, b);
    wait_idle();
    read_reg(C_MFHI, h, st);
    read_reg(C_MFLO, l, st);
    check(req, {h, l}, e);
  endtask

  initial begin
    logic [31:0] h, l, a, b;
    logic st;
    int unsigned seed_sink;
    seed_sink = $urandom(32'd24681357);
    start_i = 0; func_i = 0; rs_i = 0; rt_i = 0;
    rst_n = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1 busy", {63'b0, busy_o}, 64'd0);
    read_reg(C_MFHI, h, st);
    read_reg(C_MFLO, l, st);
    check("R1 hilo", {h, l}, 64'd0);

    // R7: exact busy window
    issue(C_MULTU, 32'd3, 32'd5);
    check("R7 busy after accept", {63'b0, busy_o}, 64'd1);
    repeat (31) @(negedge clk);
    check("R7 busy at step 31", {63'b0, busy_o}, 64'd1);
    @(negedge clk);
    check("R7 idle after 32", {63'b0, busy_o}, 64'd0);
    read_reg(C_MFLO, l, st);
    check("R7 result present", {32'b0, l}, 64'd15);

    // R2 / R3 directed
    run_and_check("R2 max unsigned", C_MULTU, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_and_check("R3 neg*pos", C_MULT, 32'hFFFF_FFFD, 32'd5);
    run_and_check("R3 neg*neg", C_MULT, 32'h8000_0000, 32'h8000_0000);
    // R4 / R5 directed
    run_and_check("R4 unsigned div", C_DIVU, 32'hFFFF_FFFF, 32'd7);
    run_and_check("R5 -7/2", C_DIV, 32'hFFFF_FFF9, 32'd2);
    run_and_check("R5 7/-2", C_DIV, 32'd7, 32'hFFFF_FFFE);
    run_and_check("R5 min/-1", C_DIV, 32'h8000_0000, 32'hFFFF_FFFF);
    // R6 zero divisor
    run_and_check("R6 unsigned by zero", C_DIVU, 32'h1234_5678, 32'd0);
    run_and_check("R6 signed neg by zero", C_DIV, 32'hF000_0001, 32'd0);

    // R8 / R9: requests while busy
    issue(C_DIVU, 32'd100, 32'd7);
    repeat (3) @(negedge clk);
    issue(C_MULTU, 32'd9, 32'd9);
    issue(C_MTHI, 32'hDEAD_BEEF, 32'd0);
    read_reg(C_MFHI, h, st);
    check("R9 stall while busy", {63'b0, st}, 64'd1);
    check("R9 no data while busy", {32'b0, h}, 64'd0);
    // accept at first issue edge; 32 steps; we are at N7 now
    repeat (25) @(negedge clk);
    check("R8 still one op running", {63'b0, busy_o}, 64'd1);
    @(negedge clk);
    check("R8 no restart", {63'b0, busy_o}, 64'd0);
    read_reg(C_MFHI, h, st);
    check("R9 no stall idle", {63'b0, st}, 64'd0);
    read_reg(C_MFLO, l, st);
    check("R8 first op result", {h, l}, {32'd2, 32'd14});

    // R10: moves
    issue(C_MTHI, 32'hCAFE_0001, 32'd0);
    check("R10 no busy", {63'b0, busy_o}, 64'd0);
    read_reg(C_MFHI, h, st);
    read_reg(C_MFLO, l, st);
    check("R10 mthi", {h, l}, {32'hCAFE_0001, 32'd14});
    issue(C_MTLO, 32'h0BAD_F00D, 32'd0);
    read_reg(C_MFHI, h, st);
    read_reg(C_MFLO, l, st);
    check("R10 mtlo", {h, l}, {32'hCAFE_0001, 32'h0BAD_F00D});

    // R11: unknown code
    issue(6'b100000, 32'h1111_1111, 32'h2222_2222);
    check("R11 no busy", {63'b0, busy_o}, 64'd0);
    read_reg(C_MFHI, h, st);
    read_reg(C_MFLO, l, st);
    check("R11 hilo unchanged", {h, l}, {32'hCAFE_0001, 32'h0BAD_F00D});

    // random mix
    for (int i = 0; i < 60; i++) begin
      a = $urandom();
      b = $urandom();
      if ((i % 10) == 9) b = 0;
      case (i % 4)
        0: run_and_check("R2 random", C_MULTU, a, b);
        1: run_and_check("R3 random", C_MULT, a, b);
        2: run_and_check((b == 0) ? "R6 random" : "R4 random", C_DIVU, a, b);
        default: run_and_check((b == 0) ? "R6 random" : "R5 random", C_DIV, a, b);
      endcase
    end

    finish_run();
  end

endmodule